// File: doc/BRIEF.md
# Byte-Serial Instruction RAM Loader

This block lets a host fill and inspect a 32-bit-wide instruction memory through a narrow 8-bit register window. The host first sets a 16-bit word pointer in two byte writes. The lower byte is only parked in a holding register, and the pointer takes effect when the upper byte arrives. The host then streams instruction bytes, least significant first, into a single data window. The block collects them, and when the fourth (top) byte arrives it stores the full word, checks its parity, and steps the pointer to the next word.

Reads through the same window return the stored word one byte at a time. They use the same byte counter, and the pointer advances once the top byte has been read. Data-window writes only reach memory while a load-enable bit is set. The top data bit of every word is a parity bit chosen so that the word has odd parity. A word that fails this test sets a sticky error bit, and the host clears that bit by writing 1 to it.

Top module: `iram_byte_loader`

## Requirements
- R1: After reset the word pointer, holding byte, byte counter, load-enable bit, error bit and the read-data output are all zero.
- R2: A write at offset 0 only stores the holding byte, and the pointer read back at offsets 0 and 1 is unchanged. A write at offset 1 loads the pointer with the written byte as its upper half and the holding byte as its lower half.
- R3: A write at offset 0 or offset 1 returns the byte counter to 0.
- R4: With load enable set, writes at offset 2 fill byte lanes 0, 1 and 2 of the word (bits 7:0, 15:8, 23:16) and then lane 3 (bits 31:24). The write to lane 3 stores the whole word at the pointer, increments the pointer by one and returns the counter to 0. The pointer never moves on the other lanes.
- R5: With load enable clear, a write at offset 2 has no effect: the counter, the pointer and the memory contents stay as they were.
- R6: Bit 31 is a parity bit, and a valid stored word has an odd number of ones across all 32 bits. Storing a word with an even count sets the error bit (control bit 1), and the word is stored anyway.
- R7: The error bit stays set until a control write carries 1 in bit 1. A control write with 0 in bit 1 leaves it unchanged.
- R8: A read at offset 2 returns the byte of the word at the pointer selected by the counter, then advances the counter. Reading lane 3 increments the pointer and returns the counter to 0. Reads do not depend on load enable.
- R9: The read-data output is updated only on the clock edge that samples a read, and it holds its value in every other cycle.
- R10: Reads at offsets 0 and 1 return the lower and upper byte of the pointer. A read at offset 3 returns the control byte: bit 0 is load enable, bit 1 is the error bit, bits 3:2 are the byte counter and the other bits are 0. A write at offset 3 sets load enable from bit 0.
- R11: The pointer wraps from 0xFFFF to 0x0000. Memory is indexed by the low 8 bits of the pointer, so pointers that differ only above bit 7 refer to the same word.
- R12: When read and write are asserted in the same cycle, only the write takes effect and the read-data output holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset. It is released synchronously inside the block. |
| bus_wr | input | 1 | Register write strobe, one access per cycle |
| bus_rd | input | 1 | Register read strobe |
| bus_off | input | 2 | Register offset: 0 pointer low, 1 pointer high, 2 data window, 3 control |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |

## Verification
The reset release passes through two synchronizer flops, so the block first responds at the third rising edge after `rst_n` goes high. Read data appears one edge after the edge that samples the read. A change to the pointer, the counter or the error bit becomes visible to a read issued in the next cycle. The bench holds a behavioural model that takes the same inputs at each rising edge, including the two-edge reset release, and compares the read-data output against it at every falling edge. Every check therefore falls exactly one edge after the access it observes.

// File: rtl/ibl_pkg.sv
package ibl_pkg;

  // Register offsets on the host port. The bench relies on these values.
  typedef enum logic [1:0] {
    OFF_PTR_LO = 2'd0,
    OFF_PTR_HI = 2'd1,
    OFF_DATA   = 2'd2,
    OFF_CTRL   = 2'd3
  } reg_off_e;

  // Control byte layout.
  localparam int unsigned CTRL_LOAD_BIT = 0;
  localparam int unsigned CTRL_ERR_BIT  = 1;
  localparam int unsigned CTRL_LANE_LSB = 2;

endpackage

// File: rtl/ibl_rst_sync.sv
module ibl_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);

  logic stage1_q;
  logic stage2_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) begin
      stage1_q <= 1'b0;
      stage2_q <= 1'b0;
    end else begin
      stage1_q <= 1'b1;
      stage2_q <= stage1_q;
    end
  end

  assign rst_n_out = stage2_q;

endmodule

// File: rtl/ibl_ptr_reg.sv
// Word pointer: the lower byte waits in a holding register until the upper byte commits both halves.
module ibl_ptr_reg #(
  parameter int unsigned BYTE_W = 8,
  localparam int unsigned PTR_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic              inc,
  input  logic [BYTE_W-1:0] wdata,
  output logic [PTR_W-1:0]  ptr
);

  logic [BYTE_W-1:0] hold_q, hold_d;
  logic [PTR_W-1:0]  ptr_q, ptr_d;

  always_comb begin
    hold_d = hold_q;
    ptr_d  = ptr_q;
    if (wr_lo) begin
      hold_d = wdata;
    end
    if (wr_hi) begin
      ptr_d = {wdata, hold_q};
    end else if (inc) begin
      ptr_d = ptr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
      ptr_q  <= '0;
    end else begin
      hold_q <= hold_d;
      ptr_q  <= ptr_d;
    end
  end

  assign ptr = ptr_q;

endmodule

// File: rtl/ibl_lane_seq.sv
// Byte-lane counter shared by reads and writes, plus the holding registers for the lower lanes.
module ibl_lane_seq #(
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned LANES  = 4,
  localparam int unsigned LANE_W = $clog2(LANES),
  localparam int unsigned DATA_W = BYTE_W * LANES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              step,
  input  logic              wr_en,
  input  logic [BYTE_W-1:0] wdata,
  output logic [LANE_W-1:0] lane,
  output logic              last,
  output logic [DATA_W-1:0] word
);

  localparam logic [LANE_W-1:0] LAST_LANE = LANE_W'(LANES - 1);

  logic [LANE_W-1:0] lane_q, lane_d;
  logic [(LANES-1)*BYTE_W-1:0] held;

  assign last = (lane_q == LAST_LANE);

  always_comb begin
    lane_d = lane_q;
    if (clear) begin
      lane_d = '0;
    end else if (step) begin
      lane_d = last ? '0 : lane_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lane_q <= '0;
    end else begin
      lane_q <= lane_d;
    end
  end

  for (genvar g = 0; g < LANES - 1; g++) begin : g_lane
    logic [BYTE_W-1:0] byte_q, byte_d;
    logic              load;

    assign load = wr_en && (lane_q == LANE_W'(g));

    always_comb begin
      byte_d = byte_q;
      if (load) begin
        byte_d = wdata;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        byte_q <= '0;
      end else begin
        byte_q <= byte_d;
      end
    end

    assign held[g*BYTE_W +: BYTE_W] = byte_q;
  end

  // The top lane comes straight from the bus, so the word is complete in the cycle of the last write.
  assign word = {wdata, held};
  assign lane = lane_q;

endmodule

// File: rtl/ibl_parity_chk.sv
module ibl_parity_chk #(
  parameter int unsigned W   = 32,
  parameter bit          ODD = 1'b1
) (
  input  logic [W-1:0] word,
  output logic         ok
);

  logic red;

  assign red = ^word;

  if (ODD) begin : g_odd
    assign ok = red;
  end else begin : g_even
    assign ok = ~red;
  end

endmodule

// File: rtl/ibl_ram.sv
module ibl_ram #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned IDX_W  = 8,
  localparam int unsigned DEPTH = 1 << IDX_W
) (
  input  logic              clk,
  input  logic              we,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      mem[idx] <= wdata;
    end
  end

  assign rdata = mem[idx];

endmodule

// File: rtl/iram_byte_loader.sv
module iram_byte_loader
  import ibl_pkg::*;
#(
  parameter int unsigned BYTE_W     = 8,
  parameter int unsigned LANES      = 4,
  parameter int unsigned IDX_W      = 8,
  parameter bit          ODD_PARITY = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [1:0]        bus_off,
  input  logic [BYTE_W-1:0] bus_wdata,
  output logic [BYTE_W-1:0] bus_rdata
);

  localparam int unsigned PTR_W  = 2 * BYTE_W;
  localparam int unsigned DATA_W = BYTE_W * LANES;
  localparam int unsigned LANE_W = $clog2(LANES);

  reg_off_e          off;
  logic              rst_sync_n;
  logic              rd_go;
  logic              wr_lo, wr_hi, wr_ctrl, wr_data_en, rd_data;
  logic              lane_step, lane_clr, word_end, ram_we;
  logic [PTR_W-1:0]  ptr;
  logic [LANE_W-1:0] lane;
  logic              lane_last;
  logic [DATA_W-1:0] asm_word;
  logic [DATA_W-1:0] ram_rword;
  logic              parity_ok;
  logic [BYTE_W-1:0] rd_byte;
  logic [BYTE_W-1:0] ctrl_view;
  logic              load_q, load_d;
  logic              err_q, err_d;
  logic [BYTE_W-1:0] rdata_q, rdata_d;

  ibl_rst_sync u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_sync_n)
  );

  // Access decode: a write wins over a read in the same cycle.
  assign off        = reg_off_e'(bus_off);
  assign rd_go      = bus_rd && !bus_wr;
  assign wr_lo      = bus_wr && (off == OFF_PTR_LO);
  assign wr_hi      = bus_wr && (off == OFF_PTR_HI);
  assign wr_ctrl    = bus_wr && (off == OFF_CTRL);
  assign wr_data_en = bus_wr && (off == OFF_DATA) && load_q;
  assign rd_data    = rd_go && (off == OFF_DATA);
  assign lane_step  = wr_data_en || rd_data;
  assign lane_clr   = wr_lo || wr_hi;
  assign word_end   = lane_step && lane_last;
  assign ram_we     = wr_data_en && lane_last;

  ibl_ptr_reg #(.BYTE_W(BYTE_W)) u_ptr (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .wr_lo (wr_lo),
    .wr_hi (wr_hi),
    .inc   (word_end),
    .wdata (bus_wdata),
    .ptr   (ptr)
  );

  ibl_lane_seq #(.BYTE_W(BYTE_W), .LANES(LANES)) u_lane (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .clear (lane_clr),
    .step  (lane_step),
    .wr_en (wr_data_en),
    .wdata (bus_wdata),
    .lane  (lane),
    .last  (lane_last),
    .word  (asm_word)
  );

  ibl_parity_chk #(.W(DATA_W), .ODD(ODD_PARITY)) u_par (
    .word (asm_word),
    .ok   (parity_ok)
  );

  ibl_ram #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_ram (
    .clk   (clk),
    .we    (ram_we),
    .idx   (ptr[IDX_W-1:0]),
    .wdata (asm_word),
    .rdata (ram_rword)
  );

  assign rd_byte = ram_rword[lane*BYTE_W +: BYTE_W];

  always_comb begin
    ctrl_view = '0;
    ctrl_view[CTRL_LOAD_BIT] = load_q;
    ctrl_view[CTRL_ERR_BIT]  = err_q;
    ctrl_view[CTRL_LANE_LSB +: LANE_W] = lane;
  end

  // Control and sticky error bit: a bad word sets the bit, writing 1 to it clears it.
  always_comb begin
    load_d = load_q;
    err_d  = err_q;
    if (wr_ctrl) begin
      load_d = bus_wdata[CTRL_LOAD_BIT];
    end
    if (ram_we && !parity_ok) begin
      err_d = 1'b1;
    end else if (wr_ctrl && bus_wdata[CTRL_ERR_BIT]) begin
      err_d = 1'b0;
    end
  end

  always_comb begin
    rdata_d = rdata_q;
    if (rd_go) begin
      unique case (off)
        OFF_PTR_LO: rdata_d = ptr[BYTE_W-1:0];
        OFF_PTR_HI: rdata_d = ptr[PTR_W-1:BYTE_W];
        OFF_DATA:   rdata_d = rd_byte;
        OFF_CTRL:   rdata_d = ctrl_view;
        default:    rdata_d = rdata_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      load_q  <= 1'b0;
      err_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      load_q  <= load_d;
      err_q   <= err_d;
      rdata_q <= rdata_d;
    end
  end

  assign bus_rdata = rdata_q;

endmodule

// File: rtl/ibl_checker.sv
module ibl_checker
  import ibl_pkg::*;
#(
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned LANE_W = 2,
  parameter int unsigned PTR_W  = 16,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned LANES  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [1:0]        bus_off,
  input logic [BYTE_W-1:0] bus_wdata,
  input logic [BYTE_W-1:0] bus_rdata,
  input logic [PTR_W-1:0]  ptr,
  input logic [LANE_W-1:0] lane,
  input logic              load_en,
  input logic              err,
  input logic              ram_we,
  input logic [DATA_W-1:0] ram_wword
);

  assert_hold_stage_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_off == OFF_PTR_LO) |=> $stable(ptr));

  assert_lane_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && (bus_off == OFF_PTR_LO || bus_off == OFF_PTR_HI)) |=> (lane == '0));

  assert_ptr_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_off == OFF_DATA && load_en && lane == LANE_W'(LANES - 1))
      |=> (ptr == PTR_W'($past(ptr) + 1'b1)));

  assert_ignore_unloaded_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_off == OFF_DATA && !load_en) |=> ($stable(lane) && $stable(ptr)));

  assert_parity_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_we && !(^ram_wword)) |=> err);

  assert_err_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (err && !(bus_wr && bus_off == OFF_CTRL && bus_wdata[CTRL_ERR_BIT])) |=> err);

  // R9 and R12: without a read that wins the port, the output holds.
  assert_rdata_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_rd && !bus_wr) |=> $stable(bus_rdata));

endmodule

bind iram_byte_loader ibl_checker #(
  .BYTE_W (BYTE_W),
  .LANE_W (LANE_W),
  .PTR_W  (PTR_W),
  .DATA_W (DATA_W),
  .LANES  (LANES)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .bus_wr    (bus_wr),
  .bus_rd    (bus_rd),
  .bus_off   (bus_off),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .ptr       (ptr),
  .lane      (lane),
  .load_en   (load_q),
  .err       (err_q),
  .ram_we    (ram_we),
  .ram_wword (asm_word)
);

// File: tb/iram_byte_loader_test.sv
module iram_byte_loader_test;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       bus_wr, bus_rd;
  logic [1:0] bus_off;
  logic [7:0] bus_wdata;
  logic [7:0] bus_rdata;

  always #10 clk = ~clk;

  iram_byte_loader uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_off   (bus_off),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata)
  );

  // Behavioural reference model
  int          m_ptr, m_hold, m_lane, m_load, m_err, m_rel;
  logic [7:0]  m_rdata;
  logic [7:0]  m_bytes [3];
  logic [31:0] m_mem [int];
  int          checks = 0;
  int          fails = 0;
  int          cycles = 0;
  bit          live = 1'b0;
  string       cur_req = "R1";

  always @(posedge clk) begin
    logic [31:0] w;
    logic [31:0] rw;
    if (!rst_n) m_rel = 0;
    if (!rst_n || m_rel < 2) begin
      m_ptr = 0; m_hold = 0; m_lane = 0; m_load = 0; m_err = 0; m_rdata = 8'h00;
      if (rst_n) m_rel++;
    end else if (bus_wr) begin
      case (bus_off)
        2'd0: begin m_hold = bus_wdata; m_lane = 0; end
        2'd1: begin m_ptr = (bus_wdata << 8) | m_hold; m_lane = 0; end
        2'd2: if (m_load != 0) begin
          if (m_lane < 3) begin
            m_bytes[m_lane] = bus_wdata;
            m_lane++;
          end else begin
            w = {bus_wdata, m_bytes[2], m_bytes[1], m_bytes[0]};
            m_mem[m_ptr & 8'hFF] = w;
            if ($countones(w) % 2 == 0) m_err = 1;
            m_ptr = (m_ptr + 1) & 16'hFFFF;
            m_lane = 0;
          end
        end
        default: begin
          m_load = bus_wdata[0];
          if (bus_wdata[1]) m_err = 0;
        end
      endcase
    end else if (bus_rd) begin
      case (bus_off)
        2'd0: m_rdata = m_ptr[7:0];
        2'd1: m_rdata = m_ptr[15:8];
        2'd2: begin
          rw = m_mem.exists(m_ptr & 8'hFF) ? m_mem[m_ptr & 8'hFF] : 32'h0;
          m_rdata = rw[m_lane*8 +: 8];
          if (m_lane == 3) begin
            m_lane = 0;
            m_ptr = (m_ptr + 1) & 16'hFFFF;
          end else begin
            m_lane++;
          end
        end
        default: m_rdata = {4'b0, m_lane[1:0], m_err[0], m_load[0]};
      endcase
    end
  end

  always @(negedge clk) begin
    if (live) begin
      checks++;
      if (bus_rdata !== m_rdata) begin
        fails++;
        $display("FAIL %s rdata=%h expected=%h at %0t", cur_req, bus_rdata, m_rdata, $time);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      fails++;
      $display("FAIL watchdog expired actual=%0d cycles expected<=100000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic drive(input bit w, input bit r, input logic [1:0] o, input logic [7:0] d);
    @(negedge clk);
    bus_wr = w; bus_rd = r; bus_off = o; bus_wdata = d;
  endtask

  task automatic wr(input logic [1:0] o, input logic [7:0] d);
    drive(1'b1, 1'b0, o, d);
  endtask

  task automatic rd(input logic [1:0] o);
    drive(1'b0, 1'b1, o, 8'h00);
  endtask

  task automatic idle();
    drive(1'b0, 1'b0, 2'd0, 8'h00);
  endtask

  task automatic set_ptr(input logic [15:0] a);
    wr(2'd0, a[7:0]);
    wr(2'd1, a[15:8]);
  endtask

  task automatic wr_word(input logic [31:0] w);
    for (int i = 0; i < 4; i++) wr(2'd2, w[i*8 +: 8]);
  endtask

  function automatic logic [31:0] odd_word(input logic [31:0] r);
    logic [31:0] w;
    w = r;
    w[31] = ~^r[30:0];
    return w;
  endfunction

  initial begin
    rst_n = 1'b0;
    bus_wr = 1'b0; bus_rd = 1'b0; bus_off = 2'd0; bus_wdata = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    live = 1'b1;
    repeat (3) idle();

    // R1: reset values through the port
    cur_req = "R1";
    rd(2'd0); rd(2'd1); rd(2'd3); idle();

    // R2: low byte is staged, high byte commits
    cur_req = "R2";
    wr(2'd0, 8'h34); rd(2'd0); rd(2'd1);
    wr(2'd1, 8'h12); rd(2'd0); rd(2'd1); idle();

    // R5: no load enable, data writes ignored
    cur_req = "R5";
    wr(2'd2, 8'hAA); wr(2'd2, 8'hBB); rd(2'd3); rd(2'd0); idle();

    // R10: control write and readback
    cur_req = "R10";
    wr(2'd3, 8'h01); rd(2'd3); idle();

    // R4: word assembly, pointer step only after top byte
    cur_req = "R4";
    wr(2'd2, 8'h01); wr(2'd2, 8'h00); rd(2'd3); rd(2'd0);
    wr(2'd2, 8'h00); wr(2'd2, 8'h00); rd(2'd0); rd(2'd3);
    wr_word(32'h8000_0000); rd(2'd0); idle();

    // R8: read back the two words byte by byte
    cur_req = "R8";
    set_ptr(16'h1234);
    for (int i = 0; i < 8; i++) rd(2'd2);
    rd(2'd0); rd(2'd3); idle();

    // R3: pointer write mid-word resets lane
    cur_req = "R3";
    wr(2'd2, 8'h55); wr(2'd2, 8'h66); rd(2'd3);
    wr(2'd0, 8'h10); rd(2'd3);
    wr(2'd2, 8'h77); rd(2'd3); wr(2'd1, 8'h00); rd(2'd3); idle();

    // R6: even-parity word sets error
    cur_req = "R6";
    set_ptr(16'h0020);
    wr_word(32'h0000_0003); rd(2'd3);
    set_ptr(16'h0020); for (int i = 0; i < 4; i++) rd(2'd2); idle();

    // R7: sticky error, cleared by writing 1
    cur_req = "R7";
    wr(2'd3, 8'h01); rd(2'd3);
    wr_word(32'h0000_0001); rd(2'd3);
    wr(2'd3, 8'h03); rd(2'd3); idle();

    // R11: pointer wrap and index aliasing
    cur_req = "R11";
    set_ptr(16'hFFFF);
    wr_word(32'h0ABC_DEF0 | {~^31'h0ABCDEF0, 31'h0});
    rd(2'd0); rd(2'd1);
    set_ptr(16'h00FF); for (int i = 0; i < 4; i++) rd(2'd2);
    rd(2'd0); rd(2'd1); idle();

    // R12: write wins over simultaneous read
    cur_req = "R12";
    rd(2'd0);
    drive(1'b1, 1'b1, 2'd3, 8'h00); idle(); idle();
    rd(2'd3);
    drive(1'b1, 1'b1, 2'd0, 8'h40); rd(2'd3); idle();

    // R9: output holds while idle
    cur_req = "R9";
    repeat (4) idle();
    wr(2'd3, 8'h01); idle(); idle();

    // R4 and R8: a run of odd-parity words written then read back
    cur_req = "R4";
    set_ptr(16'h0040);
    for (int i = 0; i < 16; i++) wr_word(odd_word($urandom));
    rd(2'd0);
    cur_req = "R8";
    set_ptr(16'h0040);
    for (int i = 0; i < 64; i++) rd(2'd2);
    rd(2'd0); rd(2'd3);
    repeat (3) idle();

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule